// File: doc/BRIEF.md
# Half-Word Burst Access Sequencer

The sequencer takes one host register request of one or two 32-bit words, each byte qualified by its own enable bit, and turns it into a short run of 16-bit accesses on a slower carrier bus. Each 16-bit half of the request that has at least one byte enabled becomes one carrier cycle. Halves with no enabled byte are skipped. Per cycle, the block drives the carrier address and a two-bit byte-lane strobe.

For reads, the half-words returned by the carrier are packed into one 64-bit completion word, which is handed back on the response port. Every carrier cycle is protected by a programmable watchdog. A cycle that gets no acknowledge within the allowed number of clocks is forced to end. The watchdog then raises a status flag and can pulse a bus-error output.

A host agent presents one request at a time and waits for the single-cycle response before sending the next. The carrier side is a plain strobe/acknowledge handshake.

Top module: `hw_burst_seq`

## Requirements
- R1: Bit b of `req_be` enables byte b, and half-word i uses enable bits 2i+1:2i. A one-word request (`req_dw2`=0) covers halves 0 and 1 and ignores `req_be[7:4]`. A two-word request covers halves 0 to 3. Each half with a non-zero enable pair gets exactly one carrier cycle, issued in ascending half order. Halves with a zero pair get none.
- R2: When the enabled bytes all lie in a single half-word, exactly one carrier cycle is issued.
- R3: The carrier half-word address of half i is `{req_waddr,1'b0} + i`, modulo 2^(AW+1). With `addr_hold` set at acceptance, every cycle of the request uses `{req_waddr,1'b0}`.
- R4: During a cycle for half i, `c_lane` equals that half's enable pair. Bit 0 is the low byte and bit 1 is the high byte.
- R5: For a write, `c_we` is high and `c_wdata` equals `req_wdata[16i+15:16i]`. For a read, `c_we` is low.
- R6: The read completion holds, in each byte position, the carrier byte returned for that half if that byte is enabled, and zero if it is not. A write response carries all-zero data.
- R7: `c_stb` stays high with a stable address and lanes until `c_ack` or the watchdog ends the cycle. It is then low for at least one clock before the next cycle.
- R8: A cycle that has held `c_stb` high for `wd_limit` clocks without `c_ack` is ended, and a limit of 0 acts as 1. For a read, the enabled bytes of that half return 8'hFF. `wd_status` is then set and stays set until the next request is accepted, which clears it.
- R9: `berr_pulse` is high for one clock per watchdog-ended cycle when `berr_en` is set, and never otherwise.
- R10: `req_ready` is low from acceptance until the response cycle. `rsp_valid` is a single-cycle pulse. A request with no enabled half completes with no carrier cycle and zero data.
- R11: After reset, `req_ready` is 1 and `c_stb`, `rsp_valid`, `wd_status`, `berr_pulse` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw2 | input | 1 | 1 = two-word request |
| req_waddr | input | AW | 32-bit word address |
| req_be | input | 8 | Byte enables |
| req_wdata | input | 64 | Write data |
| addr_hold | input | 1 | Keep one carrier address for the whole burst |
| wd_limit | input | CW | Watchdog clocks allowed per carrier cycle |
| berr_en | input | 1 | Enable bus-error pulses |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Assembled read data |
| wd_status | output | 1 | A carrier cycle of the last request timed out |
| berr_pulse | output | 1 | Bus-error pulse |
| c_stb | output | 1 | Carrier cycle strobe |
| c_we | output | 1 | Carrier write |
| c_addr | output | AW+1 | Carrier half-word address |
| c_lane | output | 2 | Carrier byte-lane strobes |
| c_wdata | output | 16 | Carrier write data |
| c_ack | input | 1 | Carrier acknowledge |
| c_rdata | input | 16 | Carrier read data |

## Verification
The hardest situation to reach is a watchdog expiry on one particular cycle in the middle of a burst, with acknowledged cycles on both sides of it. The completion then has to mix real carrier bytes, 8'hFF bytes and zero bytes in the right lanes. The bench carrier model withholds `c_ack` on chosen cycle ordinals, varies its acknowledge delay, and tags every half-word it returns with its ordinal and address. This lets the packing, the timing of the timeout and the bus-error count all be predicted arithmetically. All 256 two-word and 16 one-word enable patterns are swept as reads and writes, with and without the address hold, and an address wrap case is added.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    localparam int HALF_W = 16;
    localparam int LANES  = HALF_W / 8;
    localparam int N_HALF = 4;
    localparam int DATA_W = HALF_W * N_HALF;
    localparam int BE_W   = LANES * N_HALF;
    localparam int IDX_W  = $clog2(N_HALF + 1);
    localparam int IDX_LO = $clog2(N_HALF);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_RUN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic              dw2;
        logic              hold;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // byte value returned for one lane of a finished carrier cycle
    function automatic logic [7:0] lane_byte(input logic en, input logic tmo,
                                             input logic [7:0] raw);
        if (!en)
            return 8'h00;
        else if (tmo)
            return 8'hFF;
        else
            return raw;
    endfunction

endpackage

// File: rtl/hwb_lane_plan.sv
module hwb_lane_plan
    import hwb_pkg::*;
(
    input  logic [BE_W-1:0]   be,
    input  logic              dw2,
    input  logic [IDX_W-1:0]  from,
    output logic [N_HALF-1:0] live,
    output logic [IDX_W-1:0]  pick,
    output logic              pick_ok
);

    // a half is live when it lies inside the request length and has an enabled byte
    generate
        for (genvar h = 0; h < N_HALF; h++) begin : g_live
            if (h >= N_HALF / 2) begin : g_upper
                assign live[h] = dw2 && (|be[h*LANES +: LANES]);
            end else begin : g_lower
                assign live[h] = |be[h*LANES +: LANES];
            end
        end
    endgenerate

    // lowest live half at or above 'from'
    always_comb begin
        pick = IDX_W'(N_HALF);
        for (int k = N_HALF - 1; k >= 0; k--) begin
            if (live[k] && (IDX_W'(k) >= from))
                pick = IDX_W'(k);
        end
    end

    assign pick_ok = (pick != IDX_W'(N_HALF));

endmodule

// File: rtl/hwb_watchdog.sv
module hwb_watchdog #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ack,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end

    // cnt holds the number of completed strobe clocks in this cycle
    assign expire = run && !ack && (({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, limit});

endmodule

// File: rtl/hwb_assembler.sv
module hwb_assembler
    import hwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap,
    input  logic              tmo,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BE_W-1:0]   be,
    input  logic [HALF_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    generate
        for (genvar h = 0; h < N_HALF; h++) begin : g_half
            for (genvar b = 0; b < LANES; b++) begin : g_byte
                always_ff @(posedge clk) begin
                    if (rst || clear)
                        dout[h*HALF_W + b*8 +: 8] <= 8'h00;
                    else if (cap && (idx == IDX_W'(h)))
                        dout[h*HALF_W + b*8 +: 8] <= lane_byte(be[h*LANES + b], tmo, din[b*8 +: 8]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hw_burst_seq.sv
module hw_burst_seq
    import hwb_pkg::*;
#(
    parameter int AW = 14,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_dw2,
    input  logic [AW-1:0]     req_waddr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              addr_hold,
    input  logic [CW-1:0]     wd_limit,
    input  logic              berr_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wd_status,
    output logic              berr_pulse,
    output logic              c_stb,
    output logic              c_we,
    output logic [AW:0]       c_addr,
    output logic [LANES-1:0]  c_lane,
    output logic [HALF_W-1:0] c_wdata,
    input  logic              c_ack,
    input  logic [HALF_W-1:0] c_rdata
);

    localparam int CAW = AW + 1;

    seq_state_e        st;
    req_t              rq;
    logic [CAW-1:0]    base;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  from;
    logic [N_HALF-1:0] live;
    logic [IDX_W-1:0]  pick;
    logic              pick_ok;
    logic              expire;
    logic              run;
    logic              fin;
    logic              accept;
    logic [DATA_W-1:0] asm_data;

    assign run    = (st == ST_RUN);
    assign fin    = run && (c_ack || expire);
    assign accept = (st == ST_IDLE) && req_valid;

    hwb_lane_plan u_plan (
        .be      (rq.be),
        .dw2     (rq.dw2),
        .from    (from),
        .live    (live),
        .pick    (pick),
        .pick_ok (pick_ok)
    );

    hwb_watchdog #(.CW(CW)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .ack    (c_ack),
        .limit  (wd_limit),
        .expire (expire)
    );

    hwb_assembler u_asm (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .cap   (fin),
        .tmo   (expire),
        .idx   (idx),
        .be    (rq.be),
        .din   (c_rdata),
        .dout  (asm_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rq         <= '0;
            base       <= '0;
            idx        <= '0;
            from       <= '0;
            wd_status  <= 1'b0;
            berr_pulse <= 1'b0;
        end else begin
            berr_pulse <= expire && berr_en;
            if (expire)
                wd_status <= 1'b1;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq.write  <= req_write;
                        rq.dw2    <= req_dw2;
                        rq.hold   <= addr_hold;
                        rq.be     <= req_be;
                        rq.wdata  <= req_wdata;
                        base      <= {req_waddr, 1'b0};
                        from      <= '0;
                        wd_status <= 1'b0;
                        st        <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (pick_ok) begin
                        idx <= pick;
                        st  <= ST_RUN;
                    end else begin
                        st  <= ST_DONE;
                    end
                end
                ST_RUN: begin
                    if (fin) begin
                        from <= idx + 1'b1;
                        st   <= ST_SEL;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_DONE);
    assign rsp_rdata = rq.write ? '0 : asm_data;

    assign c_stb   = run;
    assign c_we    = run && rq.write;
    assign c_addr  = rq.hold ? base : base + CAW'(idx);
    assign c_lane  = run ? rq.be[LANES*idx[IDX_LO-1:0] +: LANES] : '0;
    assign c_wdata = rq.wdata[HALF_W*idx[IDX_LO-1:0] +: HALF_W];

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        c_stb |-> !req_ready);                                          // R10

    AST_PICK_LIVE: assert property (@(posedge clk) disable iff (rst)
        run |-> (idx < IDX_W'(N_HALF)) && live[idx[IDX_LO-1:0]]);       // R1

    AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        c_stb |-> (c_lane != '0));                                      // R4

    AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (c_stb && !c_ack && !expire) |=> (c_stb && $stable(c_addr) && $stable(c_lane))); // R7

    AST_STB_GAP: assert property (@(posedge clk) disable iff (rst)
        (c_stb && (c_ack || expire)) |=> !c_stb);                       // R7

    AST_WD_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (expire && (wd_limit > CW'(1)) && $stable(wd_limit)) |-> $past(c_stb)); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));                       // R10

    AST_BERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        berr_pulse |-> wd_status);                                      // R9

endmodule

// File: tb/test_hw_burst_seq.sv
module test_hw_burst_seq;
    import hwb_pkg::*;

    localparam int AW  = 14;
    localparam int CW  = 4;
    localparam int CAW = AW + 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic              req_write;
    logic              req_dw2;
    logic [AW-1:0]     req_waddr;
    logic [BE_W-1:0]   req_be;
    logic [DATA_W-1:0] req_wdata;
    logic              addr_hold;
    logic [CW-1:0]     wd_limit;
    logic              berr_en;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              wd_status;
    logic              berr_pulse;
    logic              c_stb;
    logic              c_we;
    logic [CAW-1:0]    c_addr;
    logic [LANES-1:0]  c_lane;
    logic [HALF_W-1:0] c_wdata;
    logic              c_ack;
    logic [HALF_W-1:0] c_rdata;

    hw_burst_seq #(.AW(AW), .CW(CW)) i_hw_burst_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_dw2    (req_dw2),
        .req_waddr  (req_waddr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .addr_hold  (addr_hold),
        .wd_limit   (wd_limit),
        .berr_en    (berr_en),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .wd_status  (wd_status),
        .berr_pulse (berr_pulse),
        .c_stb      (c_stb),
        .c_we       (c_we),
        .c_addr     (c_addr),
        .c_lane     (c_lane),
        .c_wdata    (c_wdata),
        .c_ack      (c_ack),
        .c_rdata    (c_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // carrier model state
    int             n_cyc = 0;
    int             hi = 0;
    int             unstable = 0;
    int             berr_seen = 0;
    int             ack_dly = 0;
    logic [3:0]     mute = 4'h0;
    logic           prev_stb = 1'b0;
    logic [CAW-1:0] rec_addr [8];
    logic [1:0]     rec_lane [8];
    logic           rec_we   [8];
    logic [15:0]    rec_wd   [8];
    int             rec_hi   [8];

    function automatic logic [15:0] mkdata(input int ord, input logic [CAW-1:0] a);
        logic [3:0] o;
        o = ord[3:0];
        return {o, a[11:0]} ^ 16'h5A5A;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            c_ack    <= 1'b0;
            c_rdata  <= '0;
            prev_stb = 1'b0;
        end else begin
            if (berr_pulse)
                berr_seen++;
            if (c_stb) begin
                if (!prev_stb) begin
                    if (n_cyc < 8) begin
                        rec_addr[n_cyc] = c_addr;
                        rec_lane[n_cyc] = c_lane;
                        rec_we[n_cyc]   = c_we;
                        rec_wd[n_cyc]   = c_wdata;
                    end
                    n_cyc++;
                    hi = 0;
                end else if (n_cyc >= 1 && n_cyc <= 8) begin
                    if (c_addr !== rec_addr[n_cyc-1] || c_lane !== rec_lane[n_cyc-1])
                        unstable++;
                end
                hi++;
                if (n_cyc >= 1 && n_cyc <= 8)
                    rec_hi[n_cyc-1] = hi;
                if (hi > ack_dly && !(n_cyc >= 1 && n_cyc <= 4 && mute[n_cyc-1])) begin
                    c_ack   <= 1'b1;
                    c_rdata <= mkdata(n_cyc - 1, c_addr);
                end else begin
                    c_ack   <= 1'b0;
                end
            end else begin
                c_ack <= 1'b0;
            end
            prev_stb = c_stb;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input bit two, input logic [AW-1:0] wa,
                          input logic [7:0] be, input logic [63:0] wd, input bit hold,
                          input logic [CW-1:0] lim, input logic [3:0] mu,
                          input bit ben, input int dly);
        int             exp_n;
        int             tmo_n;
        int             nh;
        int             lim_eff;
        int             wait_n;
        logic [CAW-1:0] ea [4];
        logic [1:0]     el [4];
        int             eh [4];
        bit             et [4];
        logic [63:0]    ed;
        logic [15:0]    tmp;
        exp_n   = 0;
        tmo_n   = 0;
        ed      = '0;
        nh      = two ? 4 : 2;
        lim_eff = (lim == 0) ? 1 : int'(lim);
        for (int i = 0; i < nh; i++) begin
            if (be[2*i +: 2] != 2'b00) begin
                ea[exp_n] = hold ? {wa, 1'b0} : CAW'({wa, 1'b0} + CAW'(i));
                el[exp_n] = be[2*i +: 2];
                eh[exp_n] = i;
                et[exp_n] = mu[exp_n];
                if (mu[exp_n]) tmo_n++;
                tmp = mkdata(exp_n, ea[exp_n]);
                for (int b = 0; b < 2; b++) begin
                    if (be[2*i + b])
                        ed[16*i + 8*b +: 8] = mu[exp_n] ? 8'hFF : tmp[8*b +: 8];
                end
                exp_n++;
            end
        end
        if (wr) ed = '0;

        @(negedge clk);
        n_cyc     = 0;
        unstable  = 0;
        berr_seen = 0;
        ack_dly   = dly;
        mute      = mu;
        req_write = wr;
        req_dw2   = two;
        req_waddr = wa;
        req_be    = be;
        req_wdata = wd;
        addr_hold = hold;
        wd_limit  = lim;
        berr_en   = ben;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", 64'(req_ready), 64'(0));
        wait_n = 0;
        while (!rsp_valid && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R10 response seen", 64'(rsp_valid), 64'(1));
        chk("R10 ready low at response", 64'(req_ready), 64'(0));
        if (exp_n <= 1)
            chk("R2 single half one cycle", 64'(n_cyc), 64'(exp_n));
        chk("R1 carrier cycle count", 64'(n_cyc), 64'(exp_n));
        if (n_cyc == exp_n) begin
            for (int k = 0; k < exp_n; k++) begin
                chk("R3 carrier address", 64'(rec_addr[k]), 64'(ea[k]));
                chk("R4 lane strobes", 64'(rec_lane[k]), 64'(el[k]));
                chk("R5 write flag", 64'(rec_we[k]), 64'(wr));
                if (wr)
                    chk("R5 write data", 64'(rec_wd[k]), 64'(wd[16*eh[k] +: 16]));
                if (et[k])
                    chk("R8 watchdog length", 64'(rec_hi[k]), 64'(lim_eff));
            end
        end
        chk("R7 strobe stable", 64'(unstable), 64'(0));
        chk("R6 read completion", rsp_rdata, ed);
        chk("R8 watchdog status", 64'(wd_status), 64'(tmo_n > 0));
        chk("R9 bus error pulses", 64'(berr_seen), 64'(ben ? tmo_n : 0));
        @(negedge clk);
        chk("R10 response one cycle", 64'(rsp_valid), 64'(0));
        chk("R10 ready after response", 64'(req_ready), 64'(1));
        chk("R8 status persists", 64'(wd_status), 64'(tmo_n > 0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_dw2   = 1'b0;
        req_waddr = '0;
        req_be    = '0;
        req_wdata = '0;
        addr_hold = 1'b0;
        wd_limit  = 4'd6;
        berr_en   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 reset ready", 64'(req_ready), 64'(1));
        chk("R11 reset strobe", 64'(c_stb), 64'(0));
        chk("R11 reset response", 64'(rsp_valid), 64'(0));
        chk("R11 reset status", 64'(wd_status), 64'(0));
        chk("R11 reset bus error", 64'(berr_pulse), 64'(0));
        chk("R11 reset data", rsp_rdata, 64'(0));
        rst = 1'b0;
        @(negedge clk);

        // full enable sweep: one-word and two-word, read and write
        for (int two = 0; two < 2; two++) begin
            for (int e = 0; e < (two ? 256 : 16); e++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [7:0] bev;
                    logic [AW-1:0] wa;
                    bev = two ? 8'(e) : {~4'(e), 4'(e)};
                    wa  = AW'(e * 37 + two * 5 + 64);
                    do_req(w[0], two[0], wa, bev,
                           {16'h1111 * 16'(e), 16'hC3A5 ^ 16'(e), 16'h0F0F + 16'(w), 16'(e * 7)},
                           ^bev, 4'd6, 4'h0, 1'b1, e % 3);
                end
            end
        end

        // address wrap at the top of the carrier space
        do_req(1'b0, 1'b1, {AW{1'b1}}, 8'hFF, '0, 1'b0, 4'd6, 4'h0, 1'b0, 1);
        // hold address on a full two-word write
        do_req(1'b1, 1'b1, AW'(300), 8'hFF, 64'h0123_4567_89AB_CDEF, 1'b1, 4'd6, 4'h0, 1'b0, 0);
        // timeouts in the middle of a burst, bus error enabled
        do_req(1'b0, 1'b1, AW'(512), 8'hFF, '0, 1'b0, 4'd3, 4'b0101, 1'b1, 0);
        // limit zero acts as one
        do_req(1'b0, 1'b1, AW'(17), 8'b1001_0110, '0, 1'b0, 4'd0, 4'b0001, 1'b1, 0);
        // limit one, write, bus error disabled
        do_req(1'b1, 1'b1, AW'(90), 8'b1110_0011, 64'hFEED_F00D_CAFE_BEEF, 1'b0, 4'd1, 4'b1000, 1'b0, 0);
        // long limit, sparse enables, all cycles time out
        do_req(1'b0, 1'b1, AW'(1000), 8'b0100_0010, '0, 1'b1, 4'd9, 4'b0011, 1'b1, 0);
        // slow acknowledge still inside the limit
        do_req(1'b0, 1'b1, AW'(44), 8'b0011_1100, '0, 1'b0, 4'd5, 4'h0, 1'b1, 3);
        // status cleared by the next clean request
        do_req(1'b0, 1'b0, AW'(8), 8'h0F, '0, 1'b0, 4'd6, 4'h0, 1'b1, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule